// File: doc/BRIEF.md
# Local Interrupt Controller Register Front End

This block is the register face of a per-processor interrupt controller. It takes 32-bit word accesses that fall inside a 4 KB window and decodes the byte address into a register index, one register every 16 bytes. It stores the spurious/enable word, the two-word command register, the timer initial count, the divide configuration, an error status bit and a set of local vector entries. Each vector entry has a mask bit, and the entries cover the timer, thermal, performance-counter, two local interrupt pins and error sources.

Reads use a registered address. Data is valid one cycle after the request, with `rvalid` high for that cycle. The in-service, trigger-mode and request banks live in a sibling block. So do the processor priority and the live timer count. The front end reads them through plain select/data ports. The timer block receives the timer vector entry, the initial count and the divide setting. It also receives a one-cycle pulse whenever software rewrites the timer entry or the initial count.

Any access to an index that is not decoded raises an illegal-address bit in the error register; the bus does not fault. Byte and halfword accesses do nothing: they read as zero and their writes are discarded.

Top module: `intc_reg_front`

## Requirements
- R1: The register index is byte address bits [11:4]; address bits [3:0] do not affect which register is reached.
- R2: A read request (`sel`=1, `we`=0 at a rising edge) gives `rvalid`=1 and valid `rdata` during the following cycle. In every other cycle `rvalid` is 0.
- R3: Index 0x03 reads the version word 0x0005_0011. This is 0x11 in bits [7:0] and the vector entry count minus one in bits [23:16].
- R4: After reset, every vector entry reads 0x0001_0000 (mask bit 16 only) and the spurious register reads 0x0000_00FF. The command words, the initial count, the divide register and the error register read 0.
- R5: Indices 0x32 to 0x37 hold the timer, thermal, performance, local pin 0, local pin 1 and error vector entries, in that order. Each entry is a full 32-bit read/write register. The timer entry also drives `timer_lvt`.
- R6: A word write to index 0x0F keeps only bits [8:0]. `sv_enable` equals stored bit 8.
- R7: A word write to index 0x3E keeps only bits 0, 1 and 3 (mask 0xB). The stored value drives `divide_cfg`.
- R8: The command register is two 32-bit words at indices 0x30 (low word) and 0x31 (high word), selected by the low index bit.
- R9: Indices 0x10-0x17, 0x18-0x1F and 0x20-0x27 read the in-service, trigger-mode and request banks. During the data cycle, `stat_kind` is 0, 1 or 2 respectively (3 for any other index), `stat_word` is index bits [2:0], and `rdata` equals `stat_data`. Index 0x0A reads `prio_in` and index 0x39 reads `cur_count`.
- R10: A word access (read or write) to an undecoded index sets bit 7 of the error register at index 0x28. That register reads 0x80 while the bit is set. The bit stays set until a word write to index 0x28 clears it. Writes to decoded read-only indices (0x03, 0x0A, 0x10-0x27, 0x39) change nothing and raise no error.
- R11: An access with `size` other than 2 (0 = byte, 1 = halfword, 2 = word) returns `rdata`=0 with `rvalid`=1 on reads. It stores nothing, raises no error and gives no timer pulse.
- R12: `timer_cfg_pulse` is 1 for exactly the one cycle after the edge that takes a word write to index 0x32 or 0x38, and 0 otherwise.
- R13: Index 0x38 holds the 32-bit timer initial count. It reads back in full and drives `init_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address within the 4 KB window |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rvalid is 1 |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| stat_kind | output | 2 | Bank being read: 0 in-service, 1 trigger mode, 2 request, 3 none |
| stat_word | output | 3 | Word select within the bank |
| stat_data | input | 32 | Bank word returned by the sibling block |
| prio_in | input | 32 | Processor priority from the sibling block |
| cur_count | input | 32 | Live timer count from the timer block |
| timer_lvt | output | 32 | Timer vector entry |
| init_count | output | 32 | Timer initial count |
| divide_cfg | output | 4 | Divide configuration (bits 0, 1, 3 used) |
| sv_enable | output | 1 | Software enable from the spurious register |
| timer_cfg_pulse | output | 1 | One-cycle pulse after a timer entry or initial count write |

## Verification
The bench targets the decode edges. These are the two command words, the first and last word of each status bank, the last vector entry next to the initial count, and the gap indices just outside each range. A wrong range compare would show up as data from the wrong register, or as a false error on a valid index. It also targets the error bit's stickiness and its clear-by-write, and checks that writes to read-only indices raise nothing; a design that flagged those writes, or let the bit drop, would read back the wrong error word. Narrow accesses are sent to writable and to unmapped indices. A design that decoded them would store data or raise errors. The timer pulse is checked for one cycle only, and for timer-entry and initial-count writes only. A stretched or misdirected pulse would fail there.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // register index map (index = byte address [11:4])
  localparam logic [7:0] IX_VERSION = 8'h03;
  localparam logic [7:0] IX_PRIO    = 8'h0A;
  localparam logic [7:0] IX_SPUR    = 8'h0F;
  localparam logic [7:0] IX_INSVC0  = 8'h10;
  localparam logic [7:0] IX_TRIG0   = 8'h18;
  localparam logic [7:0] IX_REQ0    = 8'h20;
  localparam logic [7:0] IX_ERR     = 8'h28;
  localparam logic [7:0] IX_CMD0    = 8'h30;
  localparam logic [7:0] IX_LVT0    = 8'h32;
  localparam logic [7:0] IX_INIT    = 8'h38;
  localparam logic [7:0] IX_CUR     = 8'h39;
  localparam logic [7:0] IX_DIV     = 8'h3E;

  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    RK_NONE, RK_VER, RK_PRIO, RK_SPUR, RK_INSVC, RK_TRIG, RK_REQ,
    RK_ERR, RK_CMD, RK_LVT, RK_INIT, RK_CUR, RK_DIV
  } reg_kind_e;

  typedef enum logic [1:0] {
    BK_INSVC = 2'd0, BK_TRIG = 2'd1, BK_REQ = 2'd2, BK_NONE = 2'd3
  } bank_e;

endpackage

// File: rtl/intc_idx_decode.sv
module intc_idx_decode
  import intc_pkg::*;
#(
  parameter int N_LVT = 6
) (
  input  logic [7:0] idx,
  output reg_kind_e  kind,
  output logic [2:0] sub
);

  localparam logic [7:0] LVT_END = IX_LVT0 + 8'(N_LVT);

  always_comb begin
    kind = RK_NONE;
    sub  = 3'd0;
    if (idx == IX_VERSION) begin
      kind = RK_VER;
    end else if (idx == IX_PRIO) begin
      kind = RK_PRIO;
    end else if (idx == IX_SPUR) begin
      kind = RK_SPUR;
    end else if (idx[7:3] == IX_INSVC0[7:3]) begin
      kind = RK_INSVC;
      sub  = idx[2:0];
    end else if (idx[7:3] == IX_TRIG0[7:3]) begin
      kind = RK_TRIG;
      sub  = idx[2:0];
    end else if (idx[7:3] == IX_REQ0[7:3]) begin
      kind = RK_REQ;
      sub  = idx[2:0];
    end else if (idx == IX_ERR) begin
      kind = RK_ERR;
    end else if (idx[7:1] == IX_CMD0[7:1]) begin
      kind = RK_CMD;
      sub  = {2'b00, idx[0]};
    end else if ((idx >= IX_LVT0) && (idx < LVT_END)) begin
      kind = RK_LVT;
      sub  = idx[2:0] - IX_LVT0[2:0];
    end else if (idx == IX_INIT) begin
      kind = RK_INIT;
    end else if (idx == IX_CUR) begin
      kind = RK_CUR;
    end else if (idx == IX_DIV) begin
      kind = RK_DIV;
    end
  end

endmodule

// File: rtl/intc_lvt_bank.sv
module intc_lvt_bank #(
  parameter int N_LVT = 6,
  parameter int DW    = 32,
  parameter int MASK_BIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] entry0
);

  localparam logic [DW-1:0] RST_VAL = DW'(1) << MASK_BIT;

  logic [DW-1:0] ents [N_LVT];

  for (genvar g = 0; g < N_LVT; g++) begin : g_ent
    logic          hit;
    logic [DW-1:0] ent_q;
    logic [DW-1:0] ent_d;

    assign hit = wr_en && (wr_sel == 3'(g));

    always_comb begin
      ent_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= RST_VAL;
      end else if (hit) begin
        ent_q <= ent_d;
      end
    end

    assign ents[g] = ent_q;

    // R5
    lvt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel == 3'(g))) |=> $stable(ents[g]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_LVT; i++) begin
      if (rd_sel == 3'(i)) rd_data = ents[i];
    end
  end

  assign entry0 = ents[0];

endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SPUR_W  = 9,
  parameter int DIV_W   = 4
) (
  input  reg_kind_e         kind,
  input  logic              sub0,
  input  logic              word_ok,
  input  logic [DW-1:0]     ver_word,
  input  logic [DW-1:0]     prio,
  input  logic [SPUR_W-1:0] spur,
  input  logic [DW-1:0]     bank_word,
  input  logic              err_ill,
  input  logic [DW-1:0]     cmd_lo,
  input  logic [DW-1:0]     cmd_hi,
  input  logic [DW-1:0]     lvt_word,
  input  logic [DW-1:0]     init_word,
  input  logic [DW-1:0]     cur_word,
  input  logic [DIV_W-1:0]  div_word,
  output logic [DW-1:0]     rdata
);

  localparam int ERR_BIT = 7;

  logic [DW-1:0] sel_word;

  always_comb begin
    unique case (kind)
      RK_VER:   sel_word = ver_word;
      RK_PRIO:  sel_word = prio;
      RK_SPUR:  sel_word = DW'(spur);
      RK_INSVC,
      RK_TRIG,
      RK_REQ:   sel_word = bank_word;
      RK_ERR:   sel_word = DW'(err_ill) << ERR_BIT;
      RK_CMD:   sel_word = sub0 ? cmd_hi : cmd_lo;
      RK_LVT:   sel_word = lvt_word;
      RK_INIT:  sel_word = init_word;
      RK_CUR:   sel_word = cur_word;
      RK_DIV:   sel_word = DW'(div_word);
      default:  sel_word = '0;
    endcase
  end

  assign rdata = word_ok ? sel_word : '0;

endmodule

// File: rtl/intc_reg_front.sv
module intc_reg_front
  import intc_pkg::*;
#(
  parameter int          N_LVT  = 6,
  parameter int          DW     = 32,
  parameter logic [7:0]  VER_ID = 8'h11,
  parameter int          SPUR_W = 9,
  parameter int          DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [11:0]      addr,
  input  logic [1:0]       size,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic [1:0]       stat_kind,
  output logic [2:0]       stat_word,
  input  logic [DW-1:0]    stat_data,
  input  logic [DW-1:0]    prio_in,
  input  logic [DW-1:0]    cur_count,
  output logic [DW-1:0]    timer_lvt,
  output logic [DW-1:0]    init_count,
  output logic [DIV_W-1:0] divide_cfg,
  output logic             sv_enable,
  output logic             timer_cfg_pulse
);

  localparam logic [SPUR_W-1:0] SPUR_RST = SPUR_W'(8'hFF);
  localparam logic [DIV_W-1:0]  DIV_KEEP = DIV_W'(4'hB);
  localparam logic [DW-1:0]     VER_WORD =
    DW'({8'(N_LVT - 1), 8'h00, VER_ID});

  // ---------------- request side decode ----------------
  logic [7:0] req_idx;
  reg_kind_e  req_kind;
  logic [2:0] req_sub;
  logic       req_word, wr_fire, rd_fire, acc_bad, timer_hit;

  assign req_idx = addr[11:4];

  intc_idx_decode #(.N_LVT(N_LVT)) u_req_dec (
    .idx  (req_idx),
    .kind (req_kind),
    .sub  (req_sub)
  );

  assign req_word  = (size == SZ_WORD);
  assign wr_fire   = sel && we && req_word;
  assign rd_fire   = sel && !we;
  assign acc_bad   = sel && req_word && (req_kind == RK_NONE);
  assign timer_hit = wr_fire && ((req_kind == RK_INIT) ||
                                 ((req_kind == RK_LVT) && (req_sub == 3'd0)));

  // ---------------- state ----------------
  logic [7:0]        rd_idx_q, rd_idx_d;
  logic              rd_word_q, rd_word_d;
  logic              rvalid_q, rvalid_d;
  logic [SPUR_W-1:0] spur_q, spur_d;
  logic [DW-1:0]     cmd_lo_q, cmd_lo_d, cmd_hi_q, cmd_hi_d;
  logic [DW-1:0]     init_q, init_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              ill_q, ill_d;
  logic              pulse_q, pulse_d;
  logic              cfg_en;

  // next-state logic
  always_comb begin
    rd_idx_d  = rd_fire ? req_idx : rd_idx_q;
    rd_word_d = rd_fire ? req_word : rd_word_q;
    rvalid_d  = rd_fire;
    pulse_d   = timer_hit;
    spur_d    = spur_q;
    cmd_lo_d  = cmd_lo_q;
    cmd_hi_d  = cmd_hi_q;
    init_d    = init_q;
    div_d     = div_q;
    ill_d     = ill_q;
    if (wr_fire) begin
      unique case (req_kind)
        RK_SPUR: spur_d = wdata[SPUR_W-1:0];
        RK_CMD: begin
          if (req_sub[0]) cmd_hi_d = wdata;
          else            cmd_lo_d = wdata;
        end
        RK_INIT: init_d = wdata;
        RK_DIV:  div_d  = wdata[DIV_W-1:0] & DIV_KEEP;
        RK_ERR:  ill_d  = 1'b0;
        default: ;
      endcase
    end
    if (acc_bad) ill_d = 1'b1;
  end

  assign cfg_en = wr_fire || acc_bad;

  // register process: read pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx_q  <= 8'h00;
      rd_word_q <= 1'b0;
      rvalid_q  <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      pulse_q  <= pulse_d;
      if (rd_fire) begin
        rd_idx_q  <= rd_idx_d;
        rd_word_q <= rd_word_d;
      end
    end
  end

  // register process: configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spur_q   <= SPUR_RST;
      cmd_lo_q <= '0;
      cmd_hi_q <= '0;
      init_q   <= '0;
      div_q    <= '0;
      ill_q    <= 1'b0;
    end else if (cfg_en) begin
      spur_q   <= spur_d;
      cmd_lo_q <= cmd_lo_d;
      cmd_hi_q <= cmd_hi_d;
      init_q   <= init_d;
      div_q    <= div_d;
      ill_q    <= ill_d;
    end
  end

  // ---------------- vector table ----------------
  reg_kind_e     rd_kind;
  logic [2:0]    rd_sub;
  logic [DW-1:0] lvt_rd;

  intc_idx_decode #(.N_LVT(N_LVT)) u_rd_dec (
    .idx  (rd_idx_q),
    .kind (rd_kind),
    .sub  (rd_sub)
  );

  intc_lvt_bank #(.N_LVT(N_LVT), .DW(DW)) u_lvt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire && (req_kind == RK_LVT)),
    .wr_sel  (req_sub),
    .wr_data (wdata),
    .rd_sel  (rd_sub),
    .rd_data (lvt_rd),
    .entry0  (timer_lvt)
  );

  // ---------------- read path ----------------
  always_comb begin
    unique case (rd_kind)
      RK_INSVC: stat_kind = BK_INSVC;
      RK_TRIG:  stat_kind = BK_TRIG;
      RK_REQ:   stat_kind = BK_REQ;
      default:  stat_kind = BK_NONE;
    endcase
  end
  assign stat_word = rd_sub;

  intc_read_mux #(.DW(DW), .SPUR_W(SPUR_W), .DIV_W(DIV_W)) u_mux (
    .kind      (rd_kind),
    .sub0      (rd_sub[0]),
    .word_ok   (rd_word_q),
    .ver_word  (VER_WORD),
    .prio      (prio_in),
    .spur      (spur_q),
    .bank_word (stat_data),
    .err_ill   (ill_q),
    .cmd_lo    (cmd_lo_q),
    .cmd_hi    (cmd_hi_q),
    .lvt_word  (lvt_rd),
    .init_word (init_q),
    .cur_word  (cur_count),
    .div_word  (div_q),
    .rdata     (rdata)
  );

  assign rvalid          = rvalid_q;
  assign init_count      = init_q;
  assign divide_cfg      = div_q;
  assign sv_enable       = spur_q[SPUR_W-1];
  assign timer_cfg_pulse = pulse_q;

  // ---------------- assertions ----------------
  // R2
  rvalid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we) |=> rvalid);

  // R2
  rvalid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !we) |=> !rvalid);

  // R11
  narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && (size != SZ_WORD)) |=> (rdata == '0));

  // R12
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timer_cfg_pulse) |-> $past(sel && we && (size == SZ_WORD) &&
      ((addr[11:4] == IX_LVT0) || (addr[11:4] == IX_INIT))));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ill_q && !(sel && we && (size == SZ_WORD) && (addr[11:4] == IX_ERR)))
      |=> ill_q);

endmodule

// File: tb/tb_intc_reg_front.sv
module tb_intc_reg_front;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, we;
  logic [11:0] addr;
  logic [1:0]  size;
  logic [31:0] wdata, rdata;
  logic        rvalid;
  logic [1:0]  stat_kind;
  logic [2:0]  stat_word;
  logic [31:0] stat_data, prio_in, cur_count;
  logic [31:0] timer_lvt, init_count;
  logic [3:0]  divide_cfg;
  logic        sv_enable, timer_cfg_pulse;

  always #5 clk = ~clk;

  intc_reg_front dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .size(size),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .stat_kind(stat_kind),
    .stat_word(stat_word), .stat_data(stat_data), .prio_in(prio_in),
    .cur_count(cur_count), .timer_lvt(timer_lvt), .init_count(init_count),
    .divide_cfg(divide_cfg), .sv_enable(sv_enable),
    .timer_cfg_pulse(timer_cfg_pulse)
  );

  // sibling bank model: word pattern encodes the request it sees
  assign stat_data = 32'h5A00_0000 | (32'(stat_kind) << 4) | 32'(stat_word);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [31:0] lvt_m [6];
  logic [8:0]  spur_m;
  logic [31:0] cmd_m [2];
  logic [31:0] init_m;
  logic [3:0]  div_m;
  logic        ill_m;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [7:0] ix);
    return (ix == 8'h03) || (ix == 8'h0A) || (ix == 8'h0F) ||
           (ix >= 8'h10 && ix <= 8'h28) || (ix >= 8'h30 && ix <= 8'h39) ||
           (ix == 8'h3E);
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] ix, input logic [1:0] sz);
    logic [31:0] k;
    if (sz != 2'd2) return 32'h0;
    if (ix == 8'h03) return 32'h0005_0011;
    if (ix == 8'h0A) return prio_in;
    if (ix == 8'h0F) return {23'h0, spur_m};
    if (ix >= 8'h10 && ix <= 8'h27) begin
      k = 32'((ix - 8'h10) >> 3);
      return 32'h5A00_0000 | (k << 4) | 32'(ix[2:0]);
    end
    if (ix == 8'h28) return {24'h0, ill_m, 7'h0};
    if (ix == 8'h30) return cmd_m[0];
    if (ix == 8'h31) return cmd_m[1];
    if (ix >= 8'h32 && ix <= 8'h37) return lvt_m[ix - 8'h32];
    if (ix == 8'h38) return init_m;
    if (ix == 8'h39) return cur_count;
    if (ix == 8'h3E) return {28'h0, div_m};
    return 32'h0;
  endfunction

  function automatic string req_of(input logic [7:0] ix, input logic [1:0] sz);
    if (sz != 2'd2) return "R11";
    if (!mapped(ix)) return "R10";
    if (ix == 8'h03) return "R3";
    if (ix == 8'h0F) return "R6";
    if (ix == 8'h28) return "R10";
    if (ix == 8'h30 || ix == 8'h31) return "R8";
    if (ix >= 8'h32 && ix <= 8'h37) return "R5";
    if (ix == 8'h38) return "R13";
    if (ix == 8'h3E) return "R7";
    return "R9";
  endfunction

  task automatic model_update(input logic [7:0] ix, input logic [1:0] sz,
                              input bit w, input logic [31:0] wd);
    if (sz != 2'd2) return;
    if (!mapped(ix)) begin
      ill_m = 1'b1;
      return;
    end
    if (!w) return;
    if (ix == 8'h0F) spur_m = wd[8:0];
    else if (ix == 8'h28) ill_m = 1'b0;
    else if (ix == 8'h30 || ix == 8'h31) cmd_m[ix[0]] = wd;
    else if (ix >= 8'h32 && ix <= 8'h37) lvt_m[ix - 8'h32] = wd;
    else if (ix == 8'h38) init_m = wd;
    else if (ix == 8'h3E) div_m = {wd[3], 1'b0, wd[1:0]};
  endtask

  // one access, then checks in the following cycle (after one register stage)
  task automatic op(input logic [11:0] a, input logic [1:0] sz, input bit w,
                    input logic [31:0] wd);
    logic [31:0] exp;
    bit          pexp;
    string       tag;
    @(negedge clk);
    sel = 1'b1; we = w; addr = a; size = sz; wdata = wd;
    tag  = req_of(a[11:4], sz);
    exp  = model_read(a[11:4], sz);
    pexp = w && (sz == 2'd2) && (a[11:4] == 8'h32 || a[11:4] == 8'h38);
    model_update(a[11:4], sz, w, wd);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    chk("R2 rvalid", 32'(rvalid), 32'(!w));
    if (!w) chk({tag, " rdata"}, rdata, exp);
    if (!w && a[11:4] >= 8'h10 && a[11:4] <= 8'h27)
      chk("R9 stat_word", 32'(stat_word), 32'(a[6:4]));
    chk("R12 pulse", 32'(timer_cfg_pulse), 32'(pexp));
    chk("R5 timer_lvt", timer_lvt, lvt_m[0]);
    chk("R13 init_count", init_count, init_m);
    chk("R7 divide_cfg", 32'(divide_cfg), 32'(div_m));
    chk("R6 sv_enable", 32'(sv_enable), 32'(spur_m[8]));
  endtask

  task automatic rd(input logic [11:0] a);
    op(a, 2'd2, 1'b0, 32'h0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    op(a, 2'd2, 1'b1, d);
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk("R2 idle rvalid", 32'(rvalid), 32'h0);
    chk("R12 idle pulse", 32'(timer_cfg_pulse), 32'h0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  logic [7:0] pool [16];

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) lvt_m[i] = 32'h0001_0000;
    spur_m = 9'h0FF; cmd_m[0] = 0; cmd_m[1] = 0;
    init_m = 0; div_m = 0; ill_m = 0;
    pool = '{8'h03, 8'h0A, 8'h0F, 8'h10, 8'h1F, 8'h20, 8'h27, 8'h28,
             8'h30, 8'h31, 8'h32, 8'h37, 8'h38, 8'h39, 8'h3E, 8'h3F};

    rst_n = 1'b0; sel = 0; we = 0; addr = 0; size = 0; wdata = 0;
    prio_in = 32'h0000_00C3; cur_count = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk("R2 reset rvalid", 32'(rvalid), 32'h0);
    chk("R12 reset pulse", 32'(timer_cfg_pulse), 32'h0);
    rst_n = 1'b1;
    idle_chk();

    // R4 reset values, R3 version
    for (int i = 0; i < 6; i++) rd(12'h320 + 12'(i << 4));
    rd(12'h0F0); rd(12'h280); rd(12'h300); rd(12'h310); rd(12'h380); rd(12'h3E0);
    chk("R4 spur reset", {23'h0, spur_m}, 32'h0000_00FF);
    rd(12'h030);

    // R1 low address bits ignored
    rd(12'h0FC); rd(12'h037);

    // R6 spurious mask and enable
    wr(12'h0F0, 32'hFFFF_FFFF); rd(12'h0F0);
    wr(12'h0F4, 32'h0000_0055); rd(12'h0F8);

    // R7 divide mask
    wr(12'h3E0, 32'hFFFF_FFFF); rd(12'h3E0);
    wr(12'h3E0, 32'h0000_0004); rd(12'h3E0);

    // R8 command words
    wr(12'h300, 32'hAAAA_0001); wr(12'h310, 32'h5555_0002);
    rd(12'h300); rd(12'h310);

    // R9 banks, priority, live count
    rd(12'h100); rd(12'h170); rd(12'h180); rd(12'h1F0); rd(12'h200); rd(12'h270);
    prio_in = 32'h0000_0041; rd(12'h0A0);
    cur_count = 32'hCAFE_0009; rd(12'h390);

    // R5 vector entries in order, last entry vs initial count
    for (int i = 0; i < 6; i++) wr(12'h320 + 12'(i << 4), 32'hB000_0000 + 32'(i));
    for (int i = 0; i < 6; i++) rd(12'h320 + 12'(i << 4));

    // R12 pulse: one cycle, only for timer entry and initial count
    wr(12'h320, 32'h0002_0031); idle_chk();
    wr(12'h380, 32'h0000_1000); idle_chk();
    wr(12'h330, 32'h0000_0000); idle_chk();
    rd(12'h380);   // R13 read back

    // R10 error bit set, sticky, cleared by write, no error on read-only writes
    rd(12'h000); rd(12'h280); rd(12'h0F0); rd(12'h280);
    wr(12'h280, 32'h0); rd(12'h280);
    wr(12'h400, 32'h1); rd(12'h280);
    wr(12'h280, 32'h0);
    wr(12'h030, 32'hFFFF_FFFF); wr(12'h100, 32'h1); wr(12'h390, 32'h1);
    rd(12'h280); rd(12'h030);
    rd(12'h3A0); rd(12'h280); wr(12'h280, 32'h0);

    // R11 narrow accesses
    op(12'h0F0, 2'd0, 1'b0, 0); op(12'h030, 2'd1, 1'b0, 0);
    op(12'h0F0, 2'd0, 1'b1, 32'h0000_0000); op(12'h380, 2'd1, 1'b1, 32'h0);
    op(12'h000, 2'd0, 1'b0, 0); op(12'hFF0, 2'd3, 1'b1, 32'h1);
    rd(12'h0F0); rd(12'h380); rd(12'h280);

    // random mix
    for (int n = 0; n < 500; n++) begin
      logic [7:0]  ix;
      logic [1:0]  sz;
      bit          w;
      logic [31:0] d;
      ix = ($urandom_range(0, 4) == 0) ? 8'($urandom) : pool[$urandom_range(0, 15)];
      sz = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
      w  = 1'($urandom_range(0, 1));
      d  = $urandom;
      prio_in = $urandom; cur_count = $urandom;
      op({ix, 4'($urandom)}, sz, w, d);
      if ($urandom_range(0, 9) == 0) idle_chk();
    end

    done = 1'b1;
    finish_run();
  end

endmodule